// File: doc/BRIEF.md
# Banked Configurable Interrupt Controller

The controller gathers external interrupt lines into banks of 32 and gives each bank a single request line toward the processor. Each line passes through a two-stage synchroniser. A per-line trigger mode then turns it into a status bit. The mode is one of level-high, level-low, rising edge or falling edge, and it is chosen by two configuration bits. An enable mask selects which status bits may raise the bank's request line.

Software reaches every bank through one flat register port. Banks are laid out back to back at a 24-byte stride. Each bank has six word registers:

| Offset | Register | Access |
|--------|----------|--------|
| 0x00 | status | read-only |
| 0x04 | enable | read/write |
| 0x08 | set | write-one |
| 0x0C | clear | write-one |
| 0x10 | polarity | read/write |
| 0x14 | trigger-type | read/write |

In edge modes a detected edge latches its status bit until software clears it. A software write to the set register can also latch a status bit, which lets software raise a request for testing.

Top module: `bank_irq_ctrl`

## Requirements
- R1: Bank b occupies byte addresses b*0x18 to b*0x18+0x17. Within a bank the word offsets are: status 0x00, enable 0x04, set 0x08, clear 0x0C, polarity 0x10, trigger-type 0x14. An address beyond the last bank, or an offset that is not one of these, reads 0, and a write to it changes nothing.
- R2: Source n is input src_i[n]. It belongs to bank n/32, at bit n%32 of that bank's registers, and it requests on irq_o[n/32]. Bank 0 drives irq_o[0].
- R3: With trigger-type bit 0 and polarity bit 1 (level-high), the status bit equals the synchronised input.
- R4: With trigger-type bit 0 and polarity bit 0 (level-low), the status bit equals the inverse of the synchronised input.
- R5: With trigger-type bit 1 and polarity bit 1 (rising), a 0-to-1 input transition sets the status bit. The bit then stays set regardless of the input until it is cleared.
- R6: With trigger-type bit 1 and polarity bit 0 (falling), a 1-to-0 input transition sets the status bit. The bit then stays set until it is cleared. No mode reacts to both edges.
- R7: Writing 1 to a clear bit zeroes a latched edge-mode status bit, and writing 0 leaves it unchanged. A clear wins over an edge detected in the same cycle.
- R8: Writing 1 to a set bit latches an edge-mode status bit, and writing 0 does nothing. In level modes, set and clear writes do not alter status, which keeps tracking the input.
- R9: irq_o[b] is high exactly when bank b's status AND enable is non-zero. It follows a status or enable change with no extra cycle.
- R10: After reset every register and every irq_o bit is 0. Set and clear read as 0. Enable, polarity and trigger-type read back what was written. Writes to status are ignored.
- R11: An input change reaches the status register on the third rising clock edge after it is applied, and not on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_BANKS*32 | Asynchronous interrupt source lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | NUM_BANKS | Per-bank processor request lines |

## Verification
The hardest case to reach is a clear write that lands in the same clock cycle as a freshly detected edge on the same line. The bench counts the synchroniser stages, starts the clear write exactly two edges after driving the input, and expects the status bit to read 0 afterwards. Besides that race, every source in every bank is swept through all four trigger modes with a toggle pattern. The expected status bit is computed from a small arithmetic model of the mode.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned LINES_PER_BANK = 32;
    localparam int unsigned BANK_SPAN      = 24;

    typedef enum logic [2:0] {
        REG_STATUS = 3'd0,
        REG_ENABLE = 3'd1,
        REG_SET    = 3'd2,
        REG_CLEAR  = 3'd3,
        REG_POL    = 3'd4,
        REG_TRIG   = 3'd5,
        REG_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [LINES_PER_BANK-1:0] en;
        logic [LINES_PER_BANK-1:0] pol;
        logic [LINES_PER_BANK-1:0] trig_edge;
        logic [LINES_PER_BANK-1:0] status;
        logic [LINES_PER_BANK-1:0] prev;
    } bank_state_t;

    function automatic reg_sel_e decode_off(input logic [4:0] off);
        reg_sel_e r;
        case (off)
            5'h00:   r = REG_STATUS;
            5'h04:   r = REG_ENABLE;
            5'h08:   r = REG_SET;
            5'h0C:   r = REG_CLEAR;
            5'h10:   r = REG_POL;
            5'h14:   r = REG_TRIG;
            default: r = REG_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[k] <= '0;
                end else begin
                    stage_q[k] <= stage_d[k];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LINES_PER_BANK-1:0] lines_i,
    input  logic                      wr_i,
    input  reg_sel_e                  sel_i,
    input  logic [LINES_PER_BANK-1:0] wdata_i,
    output logic [LINES_PER_BANK-1:0] rdata_o,
    output logic                      irq_o
);

    bank_state_t st_q, st_d;
    logic [LINES_PER_BANK-1:0] lvl, hit, set_m, clr_m, latched;

    always_comb begin
        st_d    = st_q;
        lvl     = lines_i ~^ st_q.pol;
        hit     = (lines_i & ~st_q.prev & st_q.pol) | (~lines_i & st_q.prev & ~st_q.pol);
        set_m   = (wr_i && sel_i == REG_SET)   ? wdata_i : '0;
        clr_m   = (wr_i && sel_i == REG_CLEAR) ? wdata_i : '0;
        latched = (st_q.status | hit | set_m) & ~clr_m;

        st_d.status = (latched & st_q.trig_edge) | (lvl & ~st_q.trig_edge);
        st_d.prev   = lines_i;

        if (wr_i) begin
            case (sel_i)
                REG_ENABLE: st_d.en        = wdata_i;
                REG_POL:    st_d.pol       = wdata_i;
                REG_TRIG:   st_d.trig_edge = wdata_i;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel_i)
            REG_STATUS: rdata_o = st_q.status;
            REG_ENABLE: rdata_o = st_q.en;
            REG_POL:    rdata_o = st_q.pol;
            REG_TRIG:   rdata_o = st_q.trig_edge;
            default:    rdata_o = '0;
        endcase
    end

    assign irq_o = |(st_q.status & st_q.en);

    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_m & st_q.trig_edge)) |=> ((st_q.status & $past(clr_m & st_q.trig_edge)) == '0));

    assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (($past(st_q.status & st_q.trig_edge & ~clr_m) & ~st_q.status) == '0));

    assert_level_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (((st_q.status ^ $past(lvl)) & ~$past(st_q.trig_edge)) == '0));

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> !irq_o);

endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
    import intc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_BANKS*LINES_PER_BANK-1:0] src_i,
    input  logic                                reg_we_i,
    input  logic [ADDR_W-1:0]                   reg_addr_i,
    input  logic [LINES_PER_BANK-1:0]           reg_wdata_i,
    output logic [LINES_PER_BANK-1:0]           reg_rdata_o,
    output logic [NUM_BANKS-1:0]                irq_o
);

    localparam int unsigned SRC_N = NUM_BANKS * LINES_PER_BANK;

    logic [SRC_N-1:0]          src_sync;
    logic [NUM_BANKS-1:0]      bank_hit;
    logic [LINES_PER_BANK-1:0] bank_rd [NUM_BANKS];

    intc_sync #(.WIDTH(SRC_N), .STAGES(2)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (src_sync)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam logic [ADDR_W:0] BASE  = (ADDR_W+1)'(b * BANK_SPAN);
            localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'((b + 1) * BANK_SPAN);
            logic [ADDR_W:0] rel;
            reg_sel_e        sel;

            assign bank_hit[b] = ({1'b0, reg_addr_i} >= BASE) && ({1'b0, reg_addr_i} < LIMIT);
            assign rel         = {1'b0, reg_addr_i} - BASE;
            assign sel         = bank_hit[b] ? decode_off(rel[4:0]) : REG_NONE;

            intc_bank bank_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .lines_i (src_sync[b*LINES_PER_BANK +: LINES_PER_BANK]),
                .wr_i    (reg_we_i && bank_hit[b]),
                .sel_i   (sel),
                .wdata_i (reg_wdata_i),
                .rdata_o (bank_rd[b]),
                .irq_o   (irq_o[b])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            reg_rdata_o = reg_rdata_o | bank_rd[b];
        end
    end

    assert_one_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_hit));

endmodule

// File: tb/bank_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module bank_irq_ctrl_tb_top;

    localparam int NB = 4;
    localparam int NS = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          we = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NB-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bank_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        we = 1'b1; addr = 8'(a); wdata = v;
        @(negedge clk);
        we = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        addr = 8'(a);
        #1;
        v = rdata;
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        #(8ns * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected 0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        // R10: reset state while reset is held
        step(2);
        for (int b = 0; b < NB; b++) begin
            for (int o = 0; o < 24; o += 4) begin
                rd(b*24 + o, v);
                chk(v == 0, "R10 reset regs", v, 0);
            end
        end
        chk(irq == 0, "R10 reset irq", 32'(irq), 0);
        @(negedge clk); rst_n = 1'b1;
        step(2);

        // R10 / R1: readback, stride separation, write-only reads, out-of-range
        for (int b = 0; b < NB; b++) begin
            wr(b*24 + 4,  32'hA5A5_0000 | 32'(b));
            wr(b*24 + 16, 32'h0F0F_F0F0 ^ 32'(b));
            wr(b*24 + 20, 32'h1234_5678 + 32'(b));
        end
        for (int b = 0; b < NB; b++) begin
            rd(b*24 + 4, v);  chk(v == (32'hA5A5_0000 | 32'(b)), "R1 R10 enable readback", v, 32'hA5A5_0000 | 32'(b));
            rd(b*24 + 16, v); chk(v == (32'h0F0F_F0F0 ^ 32'(b)), "R10 polarity readback", v, 32'h0F0F_F0F0 ^ 32'(b));
            rd(b*24 + 20, v); chk(v == (32'h1234_5678 + 32'(b)), "R10 trigger readback", v, 32'h1234_5678 + 32'(b));
            rd(b*24 + 8, v);  chk(v == 0, "R10 set reads zero", v, 0);
            rd(b*24 + 12, v); chk(v == 0, "R10 clear reads zero", v, 0);
            rd(b*24 + 6, v);  chk(v == 0, "R1 unaligned offset", v, 0);
        end
        wr(NB*24 + 4, 32'hFFFF_FFFF);
        rd(NB*24 + 4, v); chk(v == 0, "R1 out of range read", v, 0);
        rd((NB-1)*24 + 4, v); chk(v == (32'hA5A5_0000 | 32'(NB-1)), "R1 out of range write", v, 32'hA5A5_0000 | 32'(NB-1));
        for (int b = 0; b < NB; b++) begin
            wr(b*24 + 4, 0); wr(b*24 + 16, 32'hFFFF_FFFF); wr(b*24 + 20, 0);
        end
        step(4);
        wr(24 + 0, 32'hFFFF_FFFF);
        rd(24 + 0, v); chk(v == 0, "R10 status write ignored", v, 0);

        // R11: synchroniser latency on source 5 (level-high)
        @(negedge clk); src[5] = 1'b1;
        step(2); rd(0, v); chk(v[5] == 1'b0, "R11 not after two edges", v, 0);
        step(1); rd(0, v); chk(v[5] == 1'b1, "R11 seen after three edges", v, 32'h20);
        @(negedge clk); src[5] = 1'b0; step(4);

        // R7: clear in the same cycle as a detected rising edge on source 40
        wr(24 + 20, 32'h0000_0300);
        wr(24 + 12, 32'hFFFF_FFFF);
        @(negedge clk); src[40] = 1'b1;
        repeat (2) @(posedge clk);
        wr(24 + 12, 32'h0000_0100);
        rd(24, v); chk(v[8] == 1'b0, "R7 clear beats edge", v, 0);
        @(negedge clk); src[41] = 1'b1;
        repeat (2) @(posedge clk);
        wr(24 + 12, 32'h0000_0100);
        rd(24, v); chk(v[9] == 1'b1, "R7 clear of other bit keeps edge", v, 32'h200);
        wr(24 + 20, 0); src[40] = 1'b0; src[41] = 1'b0; step(4);
        for (int b = 0; b < NB; b++) wr(b*24 + 16, 0);

        // R2-R9: sweep every source through every trigger mode
        for (int n = 0; n < NS; n++) begin
            for (int m = 0; m < 4; m++) begin
                int b, i, base;
                bit pol, edg, st, p;
                logic [NB-1:0] eirq;
                b = n / 32; i = n % 32; base = b * 24;
                pol = m[0]; edg = m[1];
                @(negedge clk); src[n] = 1'b0;
                wr(base + 16, pol ? (32'd1 << i) : 32'd0);
                wr(base + 20, edg ? (32'd1 << i) : 32'd0);
                wr(base + 4, 32'd1 << i);
                step(4);
                wr(base + 12, 32'hFFFF_FFFF);
                st = edg ? 1'b0 : ~pol;
                p = 1'b0;
                for (int t = 0; t < 4; t++) begin
                    bit l;
                    l = (t % 2 == 0);
                    @(negedge clk); src[n] = l;
                    step(3);
                    if (edg) st = st | (pol & l & ~p) | (~pol & ~l & p);
                    else     st = pol ? l : ~l;
                    p = l;
                    rd(base, v);
                    chk(v[i] == st, $sformatf("R2 R3 R4 R5 R6 src %0d mode %0d", n, m), 32'(v[i]), 32'(st));
                    eirq = st ? (NB'(1) << b) : '0;
                    chk(irq == eirq, $sformatf("R9 irq src %0d mode %0d", n, m), 32'(irq), 32'(eirq));
                end
                wr(base + 12, 0);
                rd(base, v); chk(v[i] == st, "R7 clear zero no effect", 32'(v[i]), 32'(st));
                wr(base + 12, 32'd1 << i);
                if (edg) st = 1'b0;
                rd(base, v); chk(v[i] == st, "R7 R8 clear one", 32'(v[i]), 32'(st));
                wr(base + 8, 0);
                rd(base, v); chk(v[i] == st, "R8 set zero no effect", 32'(v[i]), 32'(st));
                wr(base + 8, 32'd1 << i);
                if (edg) st = 1'b1;
                rd(base, v); chk(v[i] == st, "R8 set one", 32'(v[i]), 32'(st));
                eirq = st ? (NB'(1) << b) : '0;
                chk(irq == eirq, "R9 irq after set", 32'(irq), 32'(eirq));
                wr(base + 4, 0);
                chk(irq == 0, "R9 masked", 32'(irq), 0);
                wr(base + 16, 0); wr(base + 20, 0);
                @(negedge clk); src[n] = 1'b0;
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule